// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit performs one of four single-bit operations on an operand that has already been fetched: a plain probe of one bit, a probe that then inverts that bit, a probe that then forces it to 0, and a probe that then forces it to 1. In every case the zero flag reports the inverse of the probed bit as it stood before any change. The other four condition flags are passed through untouched.

The caller states whether the operand came from a data register or from memory. A register operand is handled as a 32-bit value, with the bit number reduced modulo 32. A memory operand is handled as a single byte, with the bit number reduced modulo 8. The bit number comes either from a 32-bit register value or from a 16-bit extension word. The caller fetches the operand and writes it back; this block only computes. Each request is answered with a one-cycle response pulse on the following clock. The pulse carries the new word, the new flags and a write-back indication.

Top module: `bit_tm_unit`

## Requirements
- R1: `rsp_valid` is high for exactly one cycle in the clock after each cycle in which `req_valid` is high, and is low otherwise. Reset drives `rsp_valid`, `rsp_result`, `rsp_flags` and `rsp_wr` to 0.
- R2: The Z field of `rsp_flags` (bit 2) equals the complement of the selected operand bit as it was before the operation.
- R3: The X (bit 4), N (bit 3), V (bit 1) and C (bit 0) fields of `rsp_flags` equal the same fields of `flags_in` from the request.
- R4: `op_code` 00 (probe only) returns the operand unchanged within its width, with `rsp_wr` low.
- R5: `op_code` 01 returns the operand with the selected bit inverted, with `rsp_wr` high.
- R6: `op_code` 10 returns the operand with the selected bit cleared to 0, with `rsp_wr` high.
- R7: `op_code` 11 returns the operand with the selected bit set to 1, with `rsp_wr` high.
- R8: When `dest_is_mem` is 0, the operation covers all 32 operand bits and the bit number is taken modulo 32.
- R9: When `dest_is_mem` is 1, only operand bits 7:0 are used, the bit number is taken modulo 8, and `rsp_result[31:8]` is 0.
- R10: When `num_from_ext` is 1, the bit number is read from `ext_word`; when it is 0, the bit number is read from `num_reg`. Only the low bits that the modulo keeps have any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one operation per high cycle |
| op_code | input | 2 | 00 probe, 01 invert, 10 clear, 11 set |
| dest_is_mem | input | 1 | 1: byte operand from memory; 0: 32-bit register operand |
| num_from_ext | input | 1 | 1: bit number from `ext_word`; 0: from `num_reg` |
| num_reg | input | 32 | Register value holding the bit number |
| ext_word | input | 16 | Extension word holding the bit number |
| operand | input | 32 | Operand value before the operation |
| flags_in | input | 5 | Current flags: X N Z V C at bits 4 to 0 |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_result | output | 32 | Operand after the operation |
| rsp_flags | output | 5 | Flags after the operation, same layout as `flags_in` |
| rsp_wr | output | 1 | High when the result must be written back |

## Verification
Every result (`rsp_valid`, `rsp_result`, `rsp_flags` and `rsp_wr`) is due exactly one clock after the request edge, because a single register stage sits between the inputs and the outputs. The bench drives a request on a falling edge and pushes the expected values into a queue. On each later falling edge it first compares the outputs against the head of that queue, or against an idle `rsp_valid` when the queue is empty, and only then drives the next stimulus. Every output is therefore sampled half a period after the edge that loads it.

// File: rtl/bit_tm_pkg.sv
package bit_tm_pkg;

  typedef enum logic [1:0] {
    BOP_PROBE = 2'b00,
    BOP_FLIP  = 2'b01,
    BOP_CLR   = 2'b10,
    BOP_SET   = 2'b11
  } bop_e;

  localparam int FLG_W = 5;
  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
  localparam int FLG_X = 4;

  // New value of the chosen bit for a given operation and old value.
  function automatic logic bit_after(input bop_e op, input logic old_bit);
    case (op)
      BOP_FLIP: bit_after = ~old_bit;
      BOP_CLR:  bit_after = 1'b0;
      BOP_SET:  bit_after = 1'b1;
      default:  bit_after = old_bit;
    endcase
  endfunction

  // Write-back is needed for every operation except a pure probe.
  function automatic logic needs_write(input bop_e op);
    needs_write = (op != BOP_PROBE);
  endfunction

endpackage

// File: rtl/bit_tm_index.sv
module bit_tm_index #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int EXT_W  = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              num_from_ext,
  input  logic              dest_is_mem,
  input  logic [DATA_W-1:0] num_reg,
  input  logic [EXT_W-1:0]  ext_word,
  output logic [IDX_W-1:0]  bit_idx
);
  localparam logic [IDX_W-1:0] BYTE_MASK = IDX_W'(BYTE_W - 1);

  logic [IDX_W-1:0] raw_idx;

  // The modulo is a truncation: keep the low index bits only.
  assign raw_idx = num_from_ext ? ext_word[IDX_W-1:0] : num_reg[IDX_W-1:0];
  assign bit_idx = dest_is_mem ? (raw_idx & BYTE_MASK) : raw_idx;
endmodule

// File: rtl/bit_tm_alu.sv
module bit_tm_alu
  import bit_tm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              dest_is_mem,
  input  bop_e              op,
  output logic              tested_bit,
  output logic [DATA_W-1:0] next_word
);
  assign tested_bit = operand[bit_idx];

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    logic in_scope;
    logic hit;
    if (i < BYTE_W) begin : g_low
      assign in_scope = 1'b1;
    end else begin : g_high
      assign in_scope = ~dest_is_mem;
    end
    assign hit          = (bit_idx == IDX_W'(i));
    assign next_word[i] = in_scope & (hit ? bit_after(op, operand[i]) : operand[i]);
  end
endmodule

// File: rtl/bit_tm_unit.sv
module bit_tm_unit
  import bit_tm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int EXT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        op_code,
  input  logic              dest_is_mem,
  input  logic              num_from_ext,
  input  logic [DATA_W-1:0] num_reg,
  input  logic [EXT_W-1:0]  ext_word,
  input  logic [DATA_W-1:0] operand,
  input  logic [4:0]        flags_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_result,
  output logic [4:0]        rsp_flags,
  output logic              rsp_wr
);
  localparam int IDX_W = $clog2(DATA_W);

  bop_e              op;
  logic [IDX_W-1:0]  sel_idx;
  logic              tested_bit;
  logic [DATA_W-1:0] new_word;
  logic [4:0]        new_flags;

  assign op = bop_e'(op_code);

  bit_tm_index #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .EXT_W(EXT_W)) u_index (
    .num_from_ext (num_from_ext),
    .dest_is_mem  (dest_is_mem),
    .num_reg      (num_reg),
    .ext_word     (ext_word),
    .bit_idx      (sel_idx)
  );

  bit_tm_alu #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_alu (
    .operand     (operand),
    .bit_idx     (sel_idx),
    .dest_is_mem (dest_is_mem),
    .op          (op),
    .tested_bit  (tested_bit),
    .next_word   (new_word)
  );

  always_comb begin
    new_flags        = flags_in;
    new_flags[FLG_Z] = ~tested_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_result <= '0;
      rsp_flags  <= '0;
      rsp_wr     <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_result <= new_word;
        rsp_flags  <= new_flags;
        rsp_wr     <= needs_write(op);
      end
    end
  end
endmodule

// File: rtl/bit_tm_chk.sv
module bit_tm_chk
  import bit_tm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        op_code,
  input logic              dest_is_mem,
  input logic [DATA_W-1:0] operand,
  input logic [4:0]        flags_in,
  input logic [IDX_W-1:0]  bit_idx,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_result,
  input logic [4:0]        rsp_flags,
  input logic              rsp_wr
);
  logic cur_bit;
  assign cur_bit = operand[bit_idx];

  assert_pulse_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_no_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_flags[FLG_Z] == !$past(cur_bit));
  assert_flags_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_flags[FLG_X] == $past(flags_in[FLG_X])) &&
                  (rsp_flags[FLG_N] == $past(flags_in[FLG_N])) &&
                  (rsp_flags[FLG_V] == $past(flags_in[FLG_V])) &&
                  (rsp_flags[FLG_C] == $past(flags_in[FLG_C])));
  assert_probe_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_code == 2'b00) |=> !rsp_wr);
  assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_code == 2'b01) |=> rsp_wr && (rsp_result[$past(bit_idx)] != $past(cur_bit)));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_code == 2'b10) |=> rsp_wr && !rsp_result[$past(bit_idx)]);
  assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_code == 2'b11) |=> rsp_wr && rsp_result[$past(bit_idx)]);
  assert_byte_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dest_is_mem) |=> (rsp_result >> BYTE_W) == '0);
  assert_byte_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dest_is_mem |-> bit_idx < IDX_W'(BYTE_W));
endmodule

bind bit_tm_unit bit_tm_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .op_code     (op_code),
  .dest_is_mem (dest_is_mem),
  .operand     (operand),
  .flags_in    (flags_in),
  .bit_idx     (sel_idx),
  .rsp_valid   (rsp_valid),
  .rsp_result  (rsp_result),
  .rsp_flags   (rsp_flags),
  .rsp_wr      (rsp_wr)
);

// File: tb/tb_bit_tm_unit.sv
module tb_bit_tm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic        dest_is_mem = 1'b0;
  logic        num_from_ext = 1'b0;
  logic [31:0] num_reg = '0;
  logic [15:0] ext_word = '0;
  logic [31:0] operand = '0;
  logic [4:0]  flags_in = '0;
  logic        rsp_valid;
  logic [31:0] rsp_result;
  logic [4:0]  rsp_flags;
  logic        rsp_wr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] q_res[$];
  logic [4:0]  q_flg[$];
  logic        q_wr[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  bit_tm_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_code(op_code),
    .dest_is_mem(dest_is_mem), .num_from_ext(num_from_ext), .num_reg(num_reg),
    .ext_word(ext_word), .operand(operand), .flags_in(flags_in),
    .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_flags(rsp_flags), .rsp_wr(rsp_wr)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare outputs against the model; called on a falling edge.
  task automatic compare_now();
    check_eq("R1 rsp_valid", {31'd0, rsp_valid}, {31'd0, q_res.size() != 0});
    if (q_res.size() != 0) begin
      logic [31:0] er = q_res.pop_front();
      logic [4:0]  ef = q_flg.pop_front();
      logic        ew = q_wr.pop_front();
      string       tg = q_tag.pop_front();
      check_eq({tg, " result"}, rsp_result, er);
      check_eq({tg, " write-back"}, {31'd0, rsp_wr}, {31'd0, ew});
      check_eq("R2 zero flag", {31'd0, rsp_flags[2]}, {31'd0, ef[2]});
      check_eq("R3 other flags", {27'd0, rsp_flags & 5'b11011}, {27'd0, ef & 5'b11011});
    end
  endtask

  // Behavioural model: arithmetic on integers, not bit slicing.
  task automatic model(input int op, input bit mem, input bit use_ext,
                       input longint nreg, input longint ext, input longint opnd,
                       input int fin);
    longint n    = use_ext ? ext : nreg;
    longint lim  = mem ? 8 : 32;
    longint idx  = n % lim;
    longint v    = mem ? (opnd % 256) : opnd;
    longint mask = longint'(1) << idx;
    longint r;
    int     old  = int'((v >> idx) % 2);
    string  tg;
    case (op)
      0: begin r = v;          tg = "R4"; end
      1: begin r = v ^ mask;   tg = "R5"; end
      2: begin r = v & ~mask;  tg = "R6"; end
      default: begin r = v | mask; tg = "R7"; end
    endcase
    tg = {tg, mem ? " R9" : " R8", use_ext ? " R10-ext" : " R10-reg"};
    q_res.push_back(r[31:0]);
    q_flg.push_back(5'((fin & 27) + (old == 0 ? 4 : 0)));
    q_wr.push_back(op != 0);
    q_tag.push_back(tg);
  endtask

  task automatic request(input int op, input bit mem, input bit use_ext,
                         input logic [31:0] nreg, input logic [15:0] ext,
                         input logic [31:0] opnd, input logic [4:0] fin);
    @(negedge clk);
    compare_now();
    req_valid = 1'b1; op_code = 2'(op); dest_is_mem = mem; num_from_ext = use_ext;
    num_reg = nreg; ext_word = ext; operand = opnd; flags_in = fin;
    model(op, mem, use_ext, nreg, ext, opnd, fin);
  endtask

  task automatic idle();
    @(negedge clk);
    compare_now();
    req_valid = 1'b0;
    operand = ~operand;
    op_code = ~op_code;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset state of every output.
    check_eq("R1 reset valid", {31'd0, rsp_valid}, 32'd0);
    check_eq("R1 reset result", rsp_result, 32'd0);
    check_eq("R1 reset flags", {27'd0, rsp_flags}, 32'd0);
    check_eq("R1 reset wr", {31'd0, rsp_wr}, 32'd0);
    rst_n = 1'b1;
    idle();
    // R4..R7 on a register operand, top and bottom bits (R8).
    request(0, 0, 0, 32'd31, 16'h0, 32'h8000_0000, 5'b11111);
    request(1, 0, 0, 32'd31, 16'h0, 32'h8000_0000, 5'b00000);
    request(2, 0, 0, 32'd0,  16'h0, 32'hFFFF_FFFF, 5'b10101);
    request(3, 0, 0, 32'd0,  16'h0, 32'h0000_0000, 5'b01010);
    idle();
    // R8: register number 37 wraps to bit 5; large numbers wrap too.
    request(3, 0, 0, 32'd37, 16'h0, 32'h0000_0000, 5'b00100);
    request(1, 0, 0, 32'hFFFF_FFE0, 16'h0, 32'h1234_5678, 5'b11011);
    // R9: memory byte, number 15 wraps to bit 7, high operand bits dropped.
    request(2, 1, 0, 32'd15, 16'h0, 32'hABCD_EF80, 5'b00000);
    request(0, 1, 0, 32'd9,  16'h0, 32'hFFFF_FF00, 5'b11111);
    request(3, 1, 0, 32'd31, 16'h0, 32'h5A5A_5A00, 5'b01110);
    idle();
    idle();
    // R10: number from the extension word, register value differs.
    request(1, 0, 1, 32'd4,  16'hFFE3, 32'h0000_0008, 5'b10001);
    request(3, 1, 1, 32'd0,  16'h000E, 32'h0000_0000, 5'b00010);
    request(2, 0, 1, 32'd17, 16'h0010, 32'h0001_0000, 5'b01000);
    request(0, 0, 1, 32'd3,  16'h001F, 32'h7FFF_FFFF, 5'b00001);
    // Mixed stimulus, with idle gaps.
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(3) == 0) idle();
      else request(int'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                   $urandom, 16'($urandom), $urandom, 5'($urandom));
    end
    idle();
    idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule